// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block drives a data mover from a linked list of scatter/gather descriptors held in memory. When it is started with the address of the first descriptor, it fetches that descriptor's four 32-bit words through a single-outstanding word-read port. It checks the descriptor, then presents one burst request to the data mover. The burst carries a buffer address, a byte count, a direction, an ordering hint and a device transfer mode.

Once the data mover accepts the burst, the walker either finishes or fetches the next descriptor. It finishes when the descriptor is marked final. Otherwise it follows the next-descriptor pointer stored in the fourth word. The walk ends with a one-cycle `done` pulse on success. It ends with a one-cycle `err` pulse and a held cause code if it meets any of these conditions: a misaligned pointer, a descriptor with zero length, or a chain longer than the configured entry limit.

Descriptor layout, as 32-bit little-endian words at offsets 0, 4, 8 and 12:
- buffer address
- length in 8-byte units
- control word: flags in bits 7:0, mode byte in bits 15:8, upper bytes unused
- next-descriptor address

Top module: `prd_chain_walker`

## Requirements
- R1: A `start` pulse while idle, with a pointer whose low 3 bits are zero, reads exactly the four words at pointer+0, +4, +8 and +12, in that order, before any burst is issued.
- R2: Each burst presents the following fields:
  - address: word 0
  - byte count: word 1 times 8
  - `bst_dir_out`: control bit 5
  - `bst_ordered`: control bit 4
  - `bst_mode`: control bits 11:8, the low nibble of the mode byte
- R3: A burst request stays asserted with all fields stable until `bst_ready` is seen, and no memory read is requested while it is pending.
- R4: When control bit 7 is clear, the next descriptor is fetched from the address in word 3, after the burst handshake.
- R5: When control bit 7 is set, the walk ends after that burst's handshake with a single-cycle `done`, and `busy` falls. The next pointer is not read or used.
- R6: A start pointer or followed next pointer with nonzero low 3 bits ends the walk with `err` and `err_cause` = 1. No read of that pointer and no burst are made.
- R7: A descriptor whose length word is zero ends the walk with `err` and `err_cause` = 2, and no burst is issued for it.
- R8: After MAX_ENTRIES bursts without a final descriptor, the walk ends with `err` and `err_cause` = 3, and no further read is made.
- R9: A `start` pulse while `busy` is ignored; the walk in progress continues unchanged.
- R10: After reset, `busy`, `rd_req`, `bst_valid`, `done` and `err` are low, and `err_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| start_ptr | input | 32 | Address of first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: chain completed |
| err | output | 1 | One-cycle pulse: walk aborted |
| err_cause | output | 2 | Abort reason (1 misaligned, 2 zero length, 3 limit), held until next start |
| rd_req | output | 1 | Word read request, held until `rd_valid` |
| rd_addr | output | 32 | Word read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data word |
| bst_valid | output | 1 | Burst request pending |
| bst_ready | input | 1 | Data mover accepts burst |
| bst_addr | output | 32 | Burst buffer address |
| bst_bytes | output | 35 | Burst byte count |
| bst_dir_out | output | 1 | 1 = memory to device |
| bst_ordered | output | 1 | Ordered-transfer hint |
| bst_mode | output | 4 | Device DMA mode |

## Verification
The assertions check the following on every cycle:
- a pending burst holds its fields steady until `bst_ready`;
- reads and bursts never overlap;
- read requests stay put until answered;
- bursts carry a nonzero, 8-byte-multiple count;
- `done` and `err` never coincide;
- no walk issues more than MAX_ENTRIES bursts.

Only the directed scenarios can show the rest: that burst fields are taken from the right descriptor word and bit, that the walk follows next pointers in order and stops at the final flag without touching its pointer, and that each abort cause comes from the right condition. They also show that a second `start` during a walk changes nothing.

// File: rtl/prd_chain_walker.sv
module prd_chain_walker #(
  parameter int AW          = 32,
  parameter int MAX_ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_cause,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          bst_valid,
  input  logic          bst_ready,
  output logic [AW-1:0] bst_addr,
  output logic [34:0]   bst_bytes,
  output logic          bst_dir_out,
  output logic          bst_ordered,
  output logic [3:0]    bst_mode
);
  localparam int CW = $clog2(MAX_ENTRIES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_BURST} state_t;

  state_t        state;
  logic [AW-1:0] ptr;
  logic [1:0]    widx;
  logic [AW-1:0] buf_addr;
  logic [31:0]   len_units;
  logic [7:0]    flags;
  logic [3:0]    mode;
  logic [AW-1:0] next_ptr;
  logic [CW-1:0] nbursts;

  wire last_entry = flags[7];
  wire handshake  = bst_valid && bst_ready;

  assign busy        = (state != S_IDLE);
  assign rd_req      = (state == S_FETCH);
  assign rd_addr     = ptr + {{(AW-4){1'b0}}, widx, 2'b00};
  assign bst_valid   = (state == S_BURST);
  assign bst_addr    = buf_addr;
  assign bst_bytes   = {len_units, 3'b000};
  assign bst_dir_out = flags[5];
  assign bst_ordered = flags[4];
  assign bst_mode    = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      widx      <= '0;
      buf_addr  <= '0;
      len_units <= '0;
      flags     <= '0;
      mode      <= '0;
      next_ptr  <= '0;
      nbursts   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_cause <= 2'd0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_cause <= 2'd0;
          nbursts   <= '0;
          widx      <= '0;
          if (start_ptr[2:0] != 3'b000) begin
            err       <= 1'b1;
            err_cause <= 2'd1;
          end else begin
            ptr   <= start_ptr;
            state <= S_FETCH;
          end
        end
        S_FETCH: if (rd_valid) begin
          case (widx)
            2'd0: buf_addr  <= rd_data[AW-1:0];
            2'd1: len_units <= rd_data;
            2'd2: begin flags <= rd_data[7:0]; mode <= rd_data[11:8]; end
            default: next_ptr <= rd_data[AW-1:0];
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) state <= S_CHECK;
        end
        S_CHECK: begin
          if (len_units == 32'd0) begin
            err       <= 1'b1;
            err_cause <= 2'd2;
            state     <= S_IDLE;
          end else begin
            state <= S_BURST;
          end
        end
        S_BURST: if (handshake) begin
          nbursts <= nbursts + 1'b1;
          if (last_entry) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (next_ptr[2:0] != 3'b000) begin
            err       <= 1'b1;
            err_cause <= 2'd1;
            state     <= S_IDLE;
          end else if (nbursts == CW'(MAX_ENTRIES - 1)) begin
            err       <= 1'b1;
            err_cause <= 2'd3;
            state     <= S_IDLE;
          end else begin
            ptr   <= next_ptr;
            widx  <= '0;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_chain_walker_chk.sv
module prd_chain_walker_chk #(
  parameter int AW          = 32,
  parameter int MAX_ENTRIES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          bst_valid,
  input logic          bst_ready,
  input logic [AW-1:0] bst_addr,
  input logic [34:0]   bst_bytes,
  input logic          bst_dir_out,
  input logic          bst_ordered,
  input logic [3:0]    bst_mode
);
  int walk_bursts;
  always_ff @(posedge clk) begin
    if (!rst_n) walk_bursts <= 0;
    else if (start && !busy) walk_bursts <= 0;
    else if (bst_valid && bst_ready) walk_bursts <= walk_bursts + 1;
  end

  a_r3_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) && $stable(bst_bytes)
      && $stable(bst_dir_out) && $stable(bst_ordered) && $stable(bst_mode));

  a_r3_no_read_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !rd_req);

  a_r1_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  a_r7_nonzero_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_bytes != 35'd0 && bst_bytes[2:0] == 3'b000);

  a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r8_limit: assert property (@(posedge clk) disable iff (!rst_n)
    walk_bursts <= MAX_ENTRIES);
endmodule

bind prd_chain_walker prd_chain_walker_chk #(.AW(AW), .MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
  .bst_bytes(bst_bytes), .bst_dir_out(bst_dir_out), .bst_ordered(bst_ordered),
  .bst_mode(bst_mode));

// File: tb/tb_prd_chain_walker.sv
module tb_prd_chain_walker;
  localparam int MAXE = 4;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_ptr = 0;
  logic        busy, done, err, rd_req, rd_valid, bst_valid, bst_ready;
  logic [1:0]  err_cause;
  logic [31:0] rd_addr, rd_data, bst_addr;
  logic [34:0] bst_bytes;
  logic        bst_dir_out, bst_ordered;
  logic [3:0]  bst_mode;

  always #5 clk = ~clk;

  prd_chain_walker #(.AW(32), .MAX_ENTRIES(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .busy(busy), .done(done), .err(err), .err_cause(err_cause),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
    .bst_bytes(bst_bytes), .bst_dir_out(bst_dir_out), .bst_ordered(bst_ordered),
    .bst_mode(bst_mode));

  logic [31:0] mem [0:63];
  int nchk = 0, nfail = 0;
  int stall = 0, stall_cnt = 0;
  bit clr = 0;
  int nrd = 0, nb = 0, overlap = 0;
  logic [31:0] rd_log [0:31];
  logic [31:0] b_addr [0:15];
  logic [34:0] b_bytes [0:15];
  logic [5:0]  b_ctl [0:15];

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 0; rd_data <= 0; bst_ready <= 0; stall_cnt <= 0;
    end else begin
      if (rd_req && !rd_valid) begin
        rd_valid <= 1; rd_data <= mem[rd_addr[7:2]];
      end else rd_valid <= 0;
      if (bst_valid && !bst_ready) begin
        if (stall_cnt >= stall) bst_ready <= 1; else stall_cnt <= stall_cnt + 1;
      end else begin
        bst_ready <= 0; stall_cnt <= 0;
      end
    end
    if (clr) begin
      nrd <= 0; nb <= 0; overlap <= 0;
    end else begin
      if (rd_req && !rd_valid) begin
        if (nrd < 32) rd_log[nrd] <= rd_addr;
        nrd <= nrd + 1;
      end
      if (bst_valid && rd_req) overlap <= overlap + 1;
      if (bst_valid && bst_ready) begin
        if (nb < 16) begin
          b_addr[nb] <= bst_addr; b_bytes[nb] <= bst_bytes;
          b_ctl[nb] <= {bst_dir_out, bst_ordered, bst_mode};
        end
        nb <= nb + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(input int at, input logic [31:0] a, input logic [31:0] len,
                           input logic [7:0] fl, input logic [7:0] md, input logic [31:0] nx);
    mem[at/4]   = a;
    mem[at/4+1] = len;
    mem[at/4+2] = {16'h0, md, fl};
    mem[at/4+3] = nx;
  endtask

  bit got_done, got_err;
  task automatic run_walk(input logic [31:0] p, input int st, input bit poke_busy);
    stall = st;
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0; start = 1; start_ptr = p;
    @(negedge clk) start = 0;
    got_done = 0; got_err = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (done || err) break;
      if (poke_busy && i == 3) begin start = 1; start_ptr = 32'h80; end
      if (poke_busy && i == 4) start = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R10 busy", busy, 0);
    check("R10 rd_req", rd_req, 0);
    check("R10 bst_valid", bst_valid, 0);
    check("R10 done/err", {done, err}, 0);
    check("R10 err_cause", err_cause, 0);
  endtask

  task automatic t_single;
    put_entry(32'h10, 32'hABCD_0000, 32'd5, 8'hB0, 8'hF3, 32'h0000_0003);
    run_walk(32'h10, 0, 0);
    check("R5 done", {got_done, got_err}, 2'b10);
    check("R1 read count", nrd, 4);
    check("R1 read order", {rd_log[0][7:0], rd_log[1][7:0], rd_log[2][7:0], rd_log[3][7:0]}, 32'h1014181C);
    check("R2 addr", b_addr[0], 32'hABCD_0000);
    check("R2 bytes", b_bytes[0], 35'd40);
    check("R2 ctl", b_ctl[0], {1'b1, 1'b1, 4'h3});
    @(negedge clk);
    check("R5 busy low", busy, 0);
  endtask

  task automatic t_chain;
    put_entry(32'h20, 32'h1000, 32'd1, 8'h00, 8'h02, 32'h48);
    put_entry(32'h48, 32'h2000, 32'd2, 8'h20, 8'h05, 32'h30);
    put_entry(32'h30, 32'h3000, 32'd3, 8'h90, 8'h07, 32'hFF);
    run_walk(32'h20, 3, 0);
    check("R4 done", {got_done, got_err}, 2'b10);
    check("R4 bursts", nb, 3);
    check("R4 order", {b_addr[0][15:0], b_addr[1][15:0], b_addr[2][15:0]}, 48'h1000_2000_3000);
    check("R4 next fetch", rd_log[4], 32'h48);
    check("R2 bytes chain", {b_bytes[1], b_bytes[2]}, {35'd16, 35'd24});
    check("R2 ctl chain", {b_ctl[0], b_ctl[1], b_ctl[2]}, {6'h02, 6'h25, 6'h17});
    check("R3 no read while burst pending", overlap, 0);
  endtask

  task automatic t_misaligned_start;
    run_walk(32'h24, 0, 0);
    check("R6 err", {got_done, got_err, err_cause}, {2'b01, 2'd1});
    check("R6 no read", nrd, 0);
    check("R6 no burst", nb, 0);
  endtask

  task automatic t_zero_len;
    put_entry(32'h40, 32'h5000, 32'd4, 8'h00, 8'h00, 32'h50);
    put_entry(32'h50, 32'h6000, 32'd0, 8'h80, 8'h00, 32'h0);
    run_walk(32'h40, 1, 0);
    check("R7 err", {got_done, got_err, err_cause}, {2'b01, 2'd2});
    check("R7 bursts", nb, 1);
  endtask

  task automatic t_bad_next;
    put_entry(32'h60, 32'h7000, 32'd1, 8'h00, 8'h00, 32'h64);
    run_walk(32'h60, 0, 0);
    check("R6 next err", {got_done, got_err, err_cause}, {2'b01, 2'd1});
    check("R6 next bursts", nb, 1);
    check("R6 next not read", nrd, 4);
  endtask

  task automatic t_limit;
    put_entry(32'h70, 32'h8000, 32'd1, 8'h00, 8'h00, 32'h70);
    run_walk(32'h70, 0, 0);
    check("R8 err", {got_done, got_err, err_cause}, {2'b01, 2'd3});
    check("R8 bursts", nb, MAXE);
    check("R8 reads", nrd, 4 * MAXE);
  endtask

  task automatic t_start_busy;
    put_entry(32'h80, 32'h9900, 32'd9, 8'h80, 8'h00, 32'h0);
    put_entry(32'h10, 32'hABCD_0000, 32'd5, 8'hB0, 8'hF3, 32'h0);
    run_walk(32'h10, 2, 1);
    check("R9 done", {got_done, got_err}, 2'b10);
    check("R9 one burst", nb, 1);
    check("R9 original addr", b_addr[0], 32'hABCD_0000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_chain();
    t_misaligned_start();
    t_zero_len();
    t_bad_next();
    t_limit();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule